// File: doc/BRIEF.md
# Hash-Mapped Shadow Register Bank

This block is a small register bank placed beside a processor's custom-instruction unit. It captures chosen write-back results so that the custom unit gets extra operands without explicit move instructions. Each write-back carries the core destination register index, the result value and a single copy flag. The destination index goes through a reprogrammable many-to-one lookup table, which yields the shadow slot. The result lands in that slot only when the copy flag is one.

The custom unit reads two operands at once through two independent read ports. A write-first bypass lets a value written in a cycle be seen on a read port in that same cycle. A configuration port writes and reads back the lookup table. A context port writes and reads back the shadow slots, so that software can save and reload both on a task switch.

With the default parameters there are 8 slots, each 32 bits wide, and 32 core registers. The slot index is 3 bits and the core index is 5 bits.

Top module: `hsr_shadow_bank`

## Requirements
- R1: After reset, every core index i maps to slot (i mod 8) and every slot holds zero.
- R2: When `wb_copy` is 1, `wb_result` is stored at the next clock edge into the slot that the table gives for `wb_dst`.
- R3: When `wb_copy` is 0 and `ctx_we` is 0, no slot changes, whatever `wb_dst` and `wb_result` are.
- R4: Core indices that map to the same slot share it: a later copy to any of them overwrites the slot.
- R5: A table write (`map_we`, `map_core_idx`, `map_slot_in`) takes effect at the next clock edge. A copy in the same cycle uses the mapping from before the write.
- R6: `map_slot_out` shows the stored table entry for `map_core_idx`. During a table write it shows the value from before the write.
- R7: `op_a_data` and `op_b_data` are combinational reads of the slots chosen by `op_a_idx` and `op_b_idx`. The two ports work independently.
- R8: If a read port addresses the slot being written in the same cycle, it returns the value being written (write-first).
- R9: `ctx_we` writes `ctx_wdata` into slot `ctx_idx` at the next clock edge. `ctx_rdata` shows the stored contents of slot `ctx_idx`, with no bypass.
- R10: If a context write and a copy target the same slot in one cycle, the context write value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_copy | input | 1 | Copy flag of the retiring instruction (1 = copy) |
| wb_dst | input | 5 | Core destination register index |
| wb_result | input | 32 | Write-back result value |
| op_a_idx | input | 3 | Read port A slot index |
| op_a_data | output | 32 | Read port A data |
| op_b_idx | input | 3 | Read port B slot index |
| op_b_data | output | 32 | Read port B data |
| map_we | input | 1 | Table write strobe |
| map_core_idx | input | 5 | Table entry selected for write and readback |
| map_slot_in | input | 3 | New slot value for the table entry |
| map_slot_out | output | 3 | Stored slot value of the selected table entry |
| ctx_we | input | 1 | Context restore write strobe |
| ctx_idx | input | 3 | Slot selected for restore and readback |
| ctx_wdata | input | 32 | Restore data |
| ctx_rdata | output | 32 | Stored contents of the selected slot |

## Verification
Three situations are hard to reach from the ports. The first is a table rewrite in the same cycle as a copy to that same core index. The second is a restore that collides with a copy on one slot. The third is a read that hits a slot in the cycle it is written. Random stimulus rarely lines these up, so directed cycles set them up on purpose. A long random phase then mixes table writes, copies, skips and restores. In that phase the reads often land on freshly written slots. A behavioural model checks every read port and readback output on every cycle.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  // Slot that a core index selects under the direct (modulo) mapping
  function automatic int direct_slot(input int core_idx, input int depth);
    return core_idx % depth;
  endfunction

  // Write-first pick: restore beats copy beats stored value
  function automatic logic [63:0] pick_first(
    input logic        rs_hit,
    input logic        wb_hit,
    input logic [63:0] rs_val,
    input logic [63:0] wb_val,
    input logic [63:0] cur_val
  );
    if (rs_hit)      return rs_val;
    else if (wb_hit) return wb_val;
    else             return cur_val;
  endfunction

endpackage

// File: rtl/hsr_hash_table.sv
module hsr_hash_table #(
  parameter int CORE_IDX_W = 5,
  parameter int SH_DEPTH   = 8,
  parameter int SH_IDX_W   = $clog2(SH_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CORE_IDX_W-1:0] lookup_idx,
  output logic [SH_IDX_W-1:0]   lookup_slot,
  input  logic                  cfg_we,
  input  logic [CORE_IDX_W-1:0] cfg_idx,
  input  logic [SH_IDX_W-1:0]   cfg_val,
  output logic [SH_IDX_W-1:0]   cfg_rdata
);
  import hsr_pkg::*;

  localparam int CORE_N = 1 << CORE_IDX_W;

  // One truth-table column per slot-index bit
  logic [SH_IDX_W-1:0][CORE_N-1:0] lut_q;
  // Entry-wise view of the columns, used by the checks
  logic [CORE_N-1:0][SH_IDX_W-1:0] map_view;

  function automatic logic [CORE_N-1:0] reset_column(input int bit_pos);
    logic [CORE_N-1:0] col;
    for (int i = 0; i < CORE_N; i++) begin
      col[i] = 1'((direct_slot(i, SH_DEPTH) >> bit_pos) & 1);
    end
    return col;
  endfunction

  for (genvar b = 0; b < SH_IDX_W; b++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lut_q[b] <= reset_column(b);
      end else if (cfg_we) begin
        lut_q[b][cfg_idx] <= cfg_val[b];
      end
    end

    assign lookup_slot[b] = lut_q[b][lookup_idx];
    assign cfg_rdata[b]   = lut_q[b][cfg_idx];

    for (genvar e = 0; e < CORE_N; e++) begin : g_view
      assign map_view[e][b] = lut_q[b][e];
    end
  end

  // Table write lands at the next edge
  p_map_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> map_view[$past(cfg_idx)] == $past(cfg_val));

  // Table holds without a write
  p_map_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(lut_q));

endmodule

// File: rtl/hsr_entry_store.sv
module hsr_entry_store #(
  parameter int DATA_W   = 32,
  parameter int SH_DEPTH = 8,
  parameter int SH_IDX_W = $clog2(SH_DEPTH),
  parameter int N_RD     = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wb_we,
  input  logic [SH_IDX_W-1:0]            wb_slot,
  input  logic [DATA_W-1:0]              wb_data,
  input  logic                           rs_we,
  input  logic [SH_IDX_W-1:0]            rs_slot,
  input  logic [DATA_W-1:0]              rs_data,
  input  logic [N_RD-1:0][SH_IDX_W-1:0]  rd_slot,
  output logic [N_RD-1:0][DATA_W-1:0]    rd_data,
  output logic [DATA_W-1:0]              rs_rdata
);
  import hsr_pkg::*;

  logic [SH_DEPTH-1:0][DATA_W-1:0] ent_q;
  logic [SH_DEPTH-1:0]             wb_hit;
  logic [SH_DEPTH-1:0]             rs_hit;

  for (genvar i = 0; i < SH_DEPTH; i++) begin : g_ent
    assign wb_hit[i] = wb_we && (wb_slot == SH_IDX_W'(i));
    assign rs_hit[i] = rs_we && (rs_slot == SH_IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
      end else if (rs_hit[i]) begin
        ent_q[i] <= rs_data;
      end else if (wb_hit[i]) begin
        ent_q[i] <= wb_data;
      end
    end

    // Copy stores the write-back value when no restore collides
    p_copy_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_hit[i] && !rs_hit[i]) |=> ent_q[i] == $past(wb_data));

    // Restore wins on a shared slot
    p_restore_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rs_hit[i] |=> ent_q[i] == $past(rs_data));
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    logic [63:0] picked;
    always_comb begin
      picked = pick_first(rs_hit[rd_slot[p]], wb_hit[rd_slot[p]],
                          64'(rs_data), 64'(wb_data), 64'(ent_q[rd_slot[p]]));
    end
    assign rd_data[p] = picked[DATA_W-1:0];
  end

  assign rs_rdata = ent_q[rs_slot];

  // Skip cycles leave every slot untouched
  p_skip_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_we && !rs_we) |=> $stable(ent_q));

  // At most one slot takes a copy per cycle
  p_one_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_hit));

endmodule

// File: rtl/hsr_shadow_bank.sv
module hsr_shadow_bank #(
  parameter int DATA_W     = 32,
  parameter int CORE_IDX_W = 5,
  parameter int SH_DEPTH   = 8,
  parameter int SH_IDX_W   = $clog2(SH_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wb_copy,
  input  logic [CORE_IDX_W-1:0] wb_dst,
  input  logic [DATA_W-1:0]     wb_result,
  input  logic [SH_IDX_W-1:0]   op_a_idx,
  output logic [DATA_W-1:0]     op_a_data,
  input  logic [SH_IDX_W-1:0]   op_b_idx,
  output logic [DATA_W-1:0]     op_b_data,
  input  logic                  map_we,
  input  logic [CORE_IDX_W-1:0] map_core_idx,
  input  logic [SH_IDX_W-1:0]   map_slot_in,
  output logic [SH_IDX_W-1:0]   map_slot_out,
  input  logic                  ctx_we,
  input  logic [SH_IDX_W-1:0]   ctx_idx,
  input  logic [DATA_W-1:0]     ctx_wdata,
  output logic [DATA_W-1:0]     ctx_rdata
);
  localparam int N_RD = 2;

  // Named internal events
  logic                          copy_fire;
  logic [SH_IDX_W-1:0]           copy_slot;
  logic [N_RD-1:0][SH_IDX_W-1:0] rd_slot;
  logic [N_RD-1:0][DATA_W-1:0]   rd_data;

  assign copy_fire = wb_copy;

  hsr_hash_table #(
    .CORE_IDX_W (CORE_IDX_W),
    .SH_DEPTH   (SH_DEPTH),
    .SH_IDX_W   (SH_IDX_W)
  ) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .lookup_idx  (wb_dst),
    .lookup_slot (copy_slot),
    .cfg_we      (map_we),
    .cfg_idx     (map_core_idx),
    .cfg_val     (map_slot_in),
    .cfg_rdata   (map_slot_out)
  );

  assign rd_slot[0] = op_a_idx;
  assign rd_slot[1] = op_b_idx;

  hsr_entry_store #(
    .DATA_W   (DATA_W),
    .SH_DEPTH (SH_DEPTH),
    .SH_IDX_W (SH_IDX_W),
    .N_RD     (N_RD)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_we    (copy_fire),
    .wb_slot  (copy_slot),
    .wb_data  (wb_result),
    .rs_we    (ctx_we),
    .rs_slot  (ctx_idx),
    .rs_data  (ctx_wdata),
    .rd_slot  (rd_slot),
    .rd_data  (rd_data),
    .rs_rdata (ctx_rdata)
  );

  assign op_a_data = rd_data[0];
  assign op_b_data = rd_data[1];

  // A read port aimed at a slot under restore sees the restore data
  p_bypass_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_we && op_a_idx == ctx_idx) |-> op_a_data == ctx_wdata);

  // Readback on the context port reflects what the port wrote
  p_ctx_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_we && !$changed(ctx_idx)) |=> (!$stable(ctx_idx) || ctx_rdata == $past(ctx_wdata)));

endmodule

// File: tb/sim_hsr_shadow_bank.sv
`timescale 1ns/1ps
module sim_hsr_shadow_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_copy = 1'b0;
  logic [4:0]  wb_dst = '0;
  logic [31:0] wb_result = '0;
  logic [2:0]  op_a_idx = '0, op_b_idx = '0;
  logic [31:0] op_a_data, op_b_data;
  logic        map_we = 1'b0;
  logic [4:0]  map_core_idx = '0;
  logic [2:0]  map_slot_in = '0;
  logic [2:0]  map_slot_out;
  logic        ctx_we = 1'b0;
  logic [2:0]  ctx_idx = '0;
  logic [31:0] ctx_wdata = '0;
  logic [31:0] ctx_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model
  int          map_m [32];
  logic [31:0] ent_m [8];

  always #2.5 clk = ~clk;

  hsr_shadow_bank u0 (
    .clk(clk), .rst_n(rst_n), .wb_copy(wb_copy), .wb_dst(wb_dst), .wb_result(wb_result),
    .op_a_idx(op_a_idx), .op_a_data(op_a_data), .op_b_idx(op_b_idx), .op_b_data(op_b_data),
    .map_we(map_we), .map_core_idx(map_core_idx), .map_slot_in(map_slot_in),
    .map_slot_out(map_slot_out), .ctx_we(ctx_we), .ctx_idx(ctx_idx),
    .ctx_wdata(ctx_wdata), .ctx_rdata(ctx_rdata)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] seen(input int slot);
    if (ctx_we && int'(ctx_idx) == slot) return ctx_wdata;
    if (wb_copy && map_m[wb_dst] == slot) return wb_result;
    return ent_m[slot];
  endfunction

  task automatic cyc(input string tag, input logic cp, input logic [4:0] dst, input logic [31:0] res,
                     input logic [2:0] pa, input logic [2:0] pb,
                     input logic mwe, input logic [4:0] mi, input logic [2:0] mv,
                     input logic cwe, input logic [2:0] ci, input logic [31:0] cd);
    bit hit_a, hit_b;
    wb_copy = cp; wb_dst = dst; wb_result = res; op_a_idx = pa; op_b_idx = pb;
    map_we = mwe; map_core_idx = mi; map_slot_in = mv;
    ctx_we = cwe; ctx_idx = ci; ctx_wdata = cd;
    #1;
    hit_a = (cwe && ci == pa) || (cp && map_m[dst] == int'(pa));
    hit_b = (cwe && ci == pb) || (cp && map_m[dst] == int'(pb));
    chk(hit_a ? "R8" : tag, "op_a", op_a_data, seen(int'(pa)));
    chk(hit_b ? "R8" : tag, "op_b", op_b_data, seen(int'(pb)));
    chk(tag, "map_out", 32'(map_slot_out), 32'(map_m[mi]));
    chk(tag, "ctx_rd", ctx_rdata, ent_m[ci]);
    @(posedge clk);
    if (cp) ent_m[map_m[dst]] = res;
    if (cwe) ent_m[ci] = cd;
    if (mwe) map_m[mi] = int'(mv);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 5'd0, 32'd0, 3'd0, 3'd0, 0, 5'd0, 3'd0, 0, 3'd0, 32'd0);
  endtask

  task automatic scan_slots(input string tag);
    for (int i = 0; i < 8; i++)
      cyc(tag, 0, 5'(i), 32'hDEAD0000 + 32'(i), 3'(i), 3'((i + 3) % 8), 0, 5'(i), 3'd0, 0, 3'(i), 32'd0);
  endtask

  task automatic scan_map(input string tag);
    for (int i = 0; i < 32; i++)
      cyc(tag, 0, 5'd0, 32'd0, 3'd0, 3'd1, 0, 5'(i), 3'd0, 0, 3'd0, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) map_m[i] = i % 8;
    for (int i = 0; i < 8; i++) ent_m[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: direct mapping and cleared slots after reset
    scan_slots("R1");
    scan_map("R1");

    // R2: copy lands in the mapped slot
    cyc("R2", 1, 5'd3, 32'hA5A5_0003, 3'd0, 3'd1, 0, 5'd0, 3'd0, 0, 3'd0, 32'd0);
    scan_slots("R2");

    // R3: skip cycles with busy inputs change nothing
    for (int k = 0; k < 24; k++)
      cyc("R3", 0, 5'($urandom), $urandom, 3'($urandom), 3'($urandom), 0, 5'($urandom), 3'd0, 0, 3'($urandom), 32'd0);
    scan_slots("R3");

    // R4: indices 1, 9, 17, 25 share slot 1
    cyc("R4", 1, 5'd1,  32'h0000_0101, 3'd2, 3'd3, 0, 5'd0, 3'd0, 0, 3'd1, 32'd0);
    cyc("R4", 1, 5'd9,  32'h0000_0909, 3'd2, 3'd3, 0, 5'd0, 3'd0, 0, 3'd1, 32'd0);
    cyc("R4", 1, 5'd25, 32'h0000_2525, 3'd2, 3'd3, 0, 5'd0, 3'd0, 0, 3'd1, 32'd0);
    scan_slots("R4");

    // R5: remap 4 -> 6 while copying to 4 in the same cycle
    cyc("R5", 1, 5'd4, 32'h4444_0001, 3'd0, 3'd7, 1, 5'd4, 3'd6, 0, 3'd0, 32'd0);
    cyc("R5", 1, 5'd4, 32'h4444_0002, 3'd0, 3'd7, 0, 5'd4, 3'd0, 0, 3'd0, 32'd0);
    scan_slots("R5");

    // R8: read ports aimed at the slot being written
    cyc("R8", 1, 5'd5, 32'h5555_5555, 3'd5, 3'd5, 0, 5'd0, 3'd0, 0, 3'd0, 32'd0);
    idle("R8");

    // R10: restore and copy collide on slot 2
    cyc("R10", 1, 5'd2, 32'h2222_C0C0, 3'd2, 3'd0, 0, 5'd0, 3'd0, 1, 3'd2, 32'h2222_5E5E);
    scan_slots("R10");

    // R9: context restore of every slot, then readback
    for (int i = 0; i < 8; i++)
      cyc("R9", 0, 5'd0, 32'd0, 3'((i + 1) % 8), 3'd0, 0, 5'd0, 3'd0, 1, 3'(i), $urandom);
    scan_slots("R9");

    // R6: random table writes, then full readback
    for (int k = 0; k < 40; k++)
      cyc("R6", 0, 5'd0, 32'd0, 3'd0, 3'd0, 1, 5'($urandom), 3'($urandom), 0, 3'd0, 32'd0);
    scan_map("R6");

    // R7: long mixed traffic
    for (int k = 0; k < 3000; k++)
      cyc("R7", ($urandom % 3) != 0, 5'($urandom), $urandom, 3'($urandom), 3'($urandom),
          ($urandom % 8) == 0, 5'($urandom), 3'($urandom),
          ($urandom % 16) == 0, 3'($urandom), $urandom);
    scan_slots("R7");
    scan_map("R7");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule